// File: doc/BRIEF.md
# Colour LCD Controller Register Interface

This block is the register front end of a colour LCD controller. It sits on a simple 32-bit bus with a 4 KB window. It holds the configuration that the pixel fetch and timing logic further down use: four panel timing words, an upper and a lower frame base address, a control word and an interrupt mask. From the first two timing words it decodes the active line width in pixels and the panel height in lines. From the control word it brings out the enable state, the pixel depth code and the ordering flags.

A frame tick input marks the end of each frame. While the controller is enabled, each tick latches two interrupt causes, next-base-update and vertical-compare. Software reads the raw and masked causes and clears them through a write-one-to-clear register. A single interrupt line is high while any unmasked cause is pending. Read-only identification bytes sit at the top of the window. A one-cycle reload pulse follows every bus write so that downstream logic can pick up new settings.

The `VARIANT` parameter selects one of three flavours. 0 is the base layout. 1 swaps the control and mask register offsets. 2 keeps that swap and also changes the first three identification bytes.

Top module: `lcd_reg_block`

## Requirements
- R1: Registers are addressed by word index (byte address bits [11:2]). Index 0..3 is timing word 0..3, 4 is the upper base, 5 is the lower base, 6 is the mask, 7 is the control word, 8 is raw status, 9 is masked status, 10 is the clear register (reads as 0), 11 is upper current and 12 is lower current. Writes to 0..7 store all 32 bits and read back unchanged. Reads are combinational on the address.
- R2: When `VARIANT` is 1 or 2, index 6 reads and writes the control word and index 7 reads and writes the mask. Every other index is unchanged.
- R3: `activeCols` equals ((timing0 & 0xFC) + 4) * 4. It ranges from 16 to 1024, and the other timing0 bits have no effect on it.
- R4: `activeRows` equals (timing1 & 0x3FF) + 1. It ranges from 1 to 1024, and bits above 9 have no effect on it.
- R5: Control word fields are mapped as follows. Bit 0 is enable, bits [3:1] are `bppMode`, bit 8 is `bgrOrder`, bit 9 is `bigEndBytes`, bit 10 is `bigEndPixels` and bit 11 is power. `lcdEnabled` is high only when both bit 0 and bit 11 are 1.
- R6: A `frameTick` sampled high while the controller is enabled sets raw status bits 2 (next base) and 3 (vertical compare) at that edge. If a clear write falls in the same cycle, the tick wins.
- R7: A `frameTick` while the controller is disabled leaves raw status unchanged. Enablement is taken from the control word held before the edge.
- R8: A write to index 10 clears every raw status bit written as 1 and leaves the others set. Masked status reads raw AND mask. `irq` is high exactly when that value is non-zero, and it follows a mask or clear write from the edge that performs it.
- R9: Reads at byte addresses 0xFE0..0xFFC return one identification byte per word, indexed by (address-0xFE0)>>2. The bytes are 0x10,0x11,0x04,0x00,0x0D,0xF0,0x05,0xB1. For `VARIANT` 2 the first three are 0x11,0x11,0x24.
- R10: Index 11 reads the upper base and index 12 reads the lower base. Any other unmapped index reads 0, and writes to it change no register.
- R11: `cfgReload` is high for exactly the one cycle after each edge at which `busWrite` was sampled high.
- R12: After reset every register is 0, so all mapped reads return 0 and `irq`, `lcdEnabled` and `cfgReload` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrite | input | 1 | Write strobe, sampled at the rising edge |
| busAddr | input | 12 | Byte address within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| frameTick | input | 1 | End-of-frame pulse |
| activeCols | output | 11 | Decoded pixels per line |
| activeRows | output | 11 | Decoded lines per panel |
| lcdEnabled | output | 1 | Enable and power both set |
| bppMode | output | 3 | Pixel depth code |
| bgrOrder | output | 1 | Blue/red swap flag |
| bigEndBytes | output | 1 | Big-endian byte order flag |
| bigEndPixels | output | 1 | Big-endian pixel order flag |
| upperBase | output | 32 | Upper frame base address |
| lowerBase | output | 32 | Lower frame base address |
| irq | output | 1 | Combined interrupt |
| cfgReload | output | 1 | One-cycle pulse after any write |

## Verification
Three instances, one per variant, receive the same random mix of writes, reads and frame ticks. This separates the swapped and unswapped offset decodes and the two identification sets. Random control words land on all four combinations of enable and power, so ticks arrive both while enabled and while disabled, which tells R6 apart from R7. Ticks that coincide with clear writes show whether the tick takes priority. Directed vectors set the timing fields at their extremes (0 and all ones) with the neighbouring bits toggled, to show that only the decoded bits reach the width and height. Writes to unmapped and identification addresses are followed by a sweep over all registers to show that nothing moved.

// File: rtl/lcd_reg_pkg.sv
package lcd_reg_pkg;

  typedef struct packed {
    logic [3:0] wrTiming;
    logic       wrUpper;
    logic       wrLower;
    logic       wrMask;
    logic       wrCtrl;
    logic       wrClear;
  } lcdStrobes_t;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_T0,
    SEL_T1,
    SEL_T2,
    SEL_T3,
    SEL_UPPER,
    SEL_LOWER,
    SEL_MASK,
    SEL_CTRL,
    SEL_RAW,
    SEL_MASKED,
    SEL_ID
  } lcdRdSel_t;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_BPP_LSB   = 1;
  localparam int CTRL_BGR_BIT   = 8;
  localparam int CTRL_BEBYTE    = 9;
  localparam int CTRL_BEPIX     = 10;
  localparam int CTRL_PWR_BIT   = 11;
  localparam int STAT_LSB       = 2;

  function automatic logic [7:0] idByte(input logic extId, input logic [2:0] slot);
    logic [7:0] b;
    case (slot)
      3'd0:    b = extId ? 8'h11 : 8'h10;
      3'd1:    b = 8'h11;
      3'd2:    b = extId ? 8'h24 : 8'h04;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/lcd_reg_ctrl.sv
module lcd_reg_ctrl
  import lcd_reg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter bit SWAP_CM = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output lcdStrobes_t       stb,
  output lcdRdSel_t         rdSel,
  output logic [2:0]        idIdx,
  output logic              cfgReload
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              inIdSpace;
  lcdRdSel_t         sel;

  assign wordIdx   = busAddr[ADDR_W-1:2];
  assign inIdSpace = &wordIdx[WORD_W-1:3];
  assign idIdx     = wordIdx[2:0];

  always_comb begin
    sel = SEL_NONE;
    if (inIdSpace) begin
      sel = SEL_ID;
    end else begin
      case (wordIdx)
        WORD_W'(0):  sel = SEL_T0;
        WORD_W'(1):  sel = SEL_T1;
        WORD_W'(2):  sel = SEL_T2;
        WORD_W'(3):  sel = SEL_T3;
        WORD_W'(4):  sel = SEL_UPPER;
        WORD_W'(5):  sel = SEL_LOWER;
        WORD_W'(6):  sel = SWAP_CM ? SEL_CTRL : SEL_MASK;
        WORD_W'(7):  sel = SWAP_CM ? SEL_MASK : SEL_CTRL;
        WORD_W'(8):  sel = SEL_RAW;
        WORD_W'(9):  sel = SEL_MASKED;
        WORD_W'(11): sel = SEL_UPPER;
        WORD_W'(12): sel = SEL_LOWER;
        default:     sel = SEL_NONE;
      endcase
    end
  end

  assign rdSel = sel;

  always_comb begin
    stb = '0;
    if (busWrite && !inIdSpace) begin
      case (wordIdx)
        WORD_W'(0):  stb.wrTiming[0] = 1'b1;
        WORD_W'(1):  stb.wrTiming[1] = 1'b1;
        WORD_W'(2):  stb.wrTiming[2] = 1'b1;
        WORD_W'(3):  stb.wrTiming[3] = 1'b1;
        WORD_W'(4):  stb.wrUpper     = 1'b1;
        WORD_W'(5):  stb.wrLower     = 1'b1;
        WORD_W'(6):  if (SWAP_CM) stb.wrCtrl = 1'b1; else stb.wrMask = 1'b1;
        WORD_W'(7):  if (SWAP_CM) stb.wrMask = 1'b1; else stb.wrCtrl = 1'b1;
        WORD_W'(10): stb.wrClear     = 1'b1;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgReload <= 1'b0;
    else       cfgReload <= busWrite;
  end

  // R1: at most one register strobe per write
  p_onehot_strobes_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrTiming, stb.wrUpper, stb.wrLower, stb.wrMask, stb.wrCtrl, stb.wrClear}));

  // R10: writes into the identification space touch no register
  p_id_write_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && inIdSpace) |-> (stb == '0));

endmodule

// File: rtl/lcd_geom_decode.sv
module lcd_geom_decode #(
  parameter int DATA_W = 32,
  parameter int DIM_W  = 11
) (
  input  logic [DATA_W-1:0] timing0,
  input  logic [DATA_W-1:0] timing1,
  output logic [DIM_W-1:0]  cols,
  output logic [DIM_W-1:0]  rows
);

  localparam int PPL_W = 6;
  localparam int LPP_W = 10;

  logic [PPL_W-1:0] pplField;
  logic [LPP_W-1:0] lppField;

  assign pplField = timing0[7:2];
  assign lppField = timing1[LPP_W-1:0];

  // ((t0 & 0xFC) + 4) * 4 == (field + 1) * 16
  assign cols = DIM_W'((DIM_W'(pplField) + DIM_W'(1)) << 4);
  assign rows = DIM_W'(lppField) + DIM_W'(1);

endmodule

// File: rtl/lcd_reg_data.sv
module lcd_reg_data
  import lcd_reg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter bit EXT_ID = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  lcdStrobes_t       stb,
  input  lcdRdSel_t         rdSel,
  input  logic [2:0]        idIdx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frameTick,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctrlWord,
  output logic [DATA_W-1:0] timing0,
  output logic [DATA_W-1:0] timing1,
  output logic [DATA_W-1:0] upBase,
  output logic [DATA_W-1:0] loBase,
  output logic              irq,
  output logic              enabled
);

  localparam int NUM_TIMING = 4;
  localparam int STAT_W     = 2;

  logic [DATA_W-1:0] timingReg [NUM_TIMING];
  logic [DATA_W-1:0] maskReg;
  logic [STAT_W-1:0] rawStat;
  logic [STAT_W-1:0] pending;
  logic [DATA_W-1:0] rawWide;
  logic [DATA_W-1:0] maskedWide;

  for (genvar i = 0; i < NUM_TIMING; i++) begin : g_timing
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                timingReg[i] <= '0;
      else if (stb.wrTiming[i]) timingReg[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upBase   <= '0;
      loBase   <= '0;
      maskReg  <= '0;
      ctrlWord <= '0;
    end else begin
      if (stb.wrUpper) upBase   <= wdata;
      if (stb.wrLower) loBase   <= wdata;
      if (stb.wrMask)  maskReg  <= wdata;
      if (stb.wrCtrl)  ctrlWord <= wdata;
    end
  end

  assign enabled = ctrlWord[CTRL_EN_BIT] && ctrlWord[CTRL_PWR_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawStat <= '0;
    end else if (frameTick && enabled) begin
      rawStat <= '1;
    end else if (stb.wrClear) begin
      rawStat <= rawStat & ~wdata[STAT_LSB +: STAT_W];
    end
  end

  assign pending = rawStat & maskReg[STAT_LSB +: STAT_W];
  assign irq     = |pending;

  always_comb begin
    rawWide    = '0;
    maskedWide = '0;
    rawWide[STAT_LSB +: STAT_W]    = rawStat;
    maskedWide[STAT_LSB +: STAT_W] = pending;
  end

  always_comb begin
    case (rdSel)
      SEL_T0:     rdata = timingReg[0];
      SEL_T1:     rdata = timingReg[1];
      SEL_T2:     rdata = timingReg[2];
      SEL_T3:     rdata = timingReg[3];
      SEL_UPPER:  rdata = upBase;
      SEL_LOWER:  rdata = loBase;
      SEL_MASK:   rdata = maskReg;
      SEL_CTRL:   rdata = ctrlWord;
      SEL_RAW:    rdata = rawWide;
      SEL_MASKED: rdata = maskedWide;
      SEL_ID:     rdata = DATA_W'(idByte(EXT_ID, idIdx));
      default:    rdata = '0;
    endcase
  end

  assign timing0 = timingReg[0];
  assign timing1 = timingReg[1];

  // R6: an enabled tick leaves both causes set, even against a clear
  p_tick_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && enabled) |=> (rawStat == 2'b11));

  // R7: a tick while disabled and without a clear changes nothing
  p_tick_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && !enabled && !stb.wrClear) |=> $stable(rawStat));

  // R8: clearing both causes drops the interrupt on the next cycle
  p_clear_drops_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrClear && (wdata[STAT_LSB +: STAT_W] == 2'b11) && !(frameTick && enabled))
      |=> !irq);

  // R8: a zero mask write silences the interrupt next cycle
  p_mask_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrMask && (wdata[STAT_LSB +: STAT_W] == 2'b00)) |=> !irq);

endmodule

// File: rtl/lcd_reg_block.sv
module lcd_reg_block
  import lcd_reg_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int DIM_W   = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              frameTick,
  output logic [DIM_W-1:0]  activeCols,
  output logic [DIM_W-1:0]  activeRows,
  output logic              lcdEnabled,
  output logic [2:0]        bppMode,
  output logic              bgrOrder,
  output logic              bigEndBytes,
  output logic              bigEndPixels,
  output logic [DATA_W-1:0] upperBase,
  output logic [DATA_W-1:0] lowerBase,
  output logic              irq,
  output logic              cfgReload
);

  localparam bit SWAP_CM = (VARIANT != 0);
  localparam bit EXT_ID  = (VARIANT == 2);

  lcdStrobes_t       stb;
  lcdRdSel_t         rdSel;
  logic [2:0]        idIdx;
  logic [DATA_W-1:0] ctrlWord;
  logic [DATA_W-1:0] timing0;
  logic [DATA_W-1:0] timing1;

  lcd_reg_ctrl #(
    .ADDR_W (ADDR_W),
    .SWAP_CM(SWAP_CM)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .stb      (stb),
    .rdSel    (rdSel),
    .idIdx    (idIdx),
    .cfgReload(cfgReload)
  );

  lcd_reg_data #(
    .DATA_W(DATA_W),
    .EXT_ID(EXT_ID)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rdSel    (rdSel),
    .idIdx    (idIdx),
    .wdata    (busWdata),
    .frameTick(frameTick),
    .rdata    (busRdata),
    .ctrlWord (ctrlWord),
    .timing0  (timing0),
    .timing1  (timing1),
    .upBase   (upperBase),
    .loBase   (lowerBase),
    .irq      (irq),
    .enabled  (lcdEnabled)
  );

  lcd_geom_decode #(
    .DATA_W(DATA_W),
    .DIM_W (DIM_W)
  ) u_geom (
    .timing0(timing0),
    .timing1(timing1),
    .cols   (activeCols),
    .rows   (activeRows)
  );

  assign bppMode      = ctrlWord[CTRL_BPP_LSB +: 3];
  assign bgrOrder     = ctrlWord[CTRL_BGR_BIT];
  assign bigEndBytes  = ctrlWord[CTRL_BEBYTE];
  assign bigEndPixels = ctrlWord[CTRL_BEPIX];

endmodule

// File: tb/lcd_reg_block_bench.sv
module lcd_reg_block_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        frameTick = 1'b0;

  logic [31:0] rd       [3];
  logic [10:0] cols     [3];
  logic [10:0] rows     [3];
  logic        en       [3];
  logic [2:0]  bpp      [3];
  logic        bgr      [3];
  logic        beb      [3];
  logic        bep      [3];
  logic [31:0] upB      [3];
  logic [31:0] loB      [3];
  logic        irqO     [3];
  logic        rel      [3];

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lcd_reg_block #(.VARIANT(0)) u_lcd_reg_block (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(rd[0]), .frameTick(frameTick), .activeCols(cols[0]), .activeRows(rows[0]),
    .lcdEnabled(en[0]), .bppMode(bpp[0]), .bgrOrder(bgr[0]), .bigEndBytes(beb[0]),
    .bigEndPixels(bep[0]), .upperBase(upB[0]), .lowerBase(loB[0]), .irq(irqO[0]),
    .cfgReload(rel[0]));

  lcd_reg_block #(.VARIANT(1)) u_lcd_reg_block_swap (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(rd[1]), .frameTick(frameTick), .activeCols(cols[1]), .activeRows(rows[1]),
    .lcdEnabled(en[1]), .bppMode(bpp[1]), .bgrOrder(bgr[1]), .bigEndBytes(beb[1]),
    .bigEndPixels(bep[1]), .upperBase(upB[1]), .lowerBase(loB[1]), .irq(irqO[1]),
    .cfgReload(rel[1]));

  lcd_reg_block #(.VARIANT(2)) u_lcd_reg_block_ext (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(rd[2]), .frameTick(frameTick), .activeCols(cols[2]), .activeRows(rows[2]),
    .lcdEnabled(en[2]), .bppMode(bpp[2]), .bgrOrder(bgr[2]), .bigEndBytes(beb[2]),
    .bigEndPixels(bep[2]), .upperBase(upB[2]), .lowerBase(loB[2]), .irq(irqO[2]),
    .cfgReload(rel[2]));

  // reference state, one copy per variant
  logic [31:0] mT    [3][4];
  logic [31:0] mUp   [3];
  logic [31:0] mLo   [3];
  logic [31:0] mCtrl [3];
  logic [31:0] mMask [3];
  logic [1:0]  mRaw  [3];
  logic        mRel;

  function automatic logic mEn(input int v);
    return mCtrl[v][0] && mCtrl[v][11];
  endfunction

  function automatic logic [7:0] expId(input int v, input int slot);
    case (slot)
      0: return (v == 2) ? 8'h11 : 8'h10;
      1: return 8'h11;
      2: return (v == 2) ? 8'h24 : 8'h04;
      3: return 8'h00;
      4: return 8'h0D;
      5: return 8'hF0;
      6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  function automatic logic [31:0] expRead(input int v, input int idx);
    if (idx >= 'h3F8) return {24'd0, expId(v, idx - 'h3F8)};
    case (idx)
      0, 1, 2, 3: return mT[v][idx];
      4, 11: return mUp[v];
      5, 12: return mLo[v];
      6: return (v != 0) ? mCtrl[v] : mMask[v];
      7: return (v != 0) ? mMask[v] : mCtrl[v];
      8: return {28'd0, mRaw[v], 2'b00};
      9: return {28'd0, mRaw[v] & mMask[v][3:2], 2'b00};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [10:0] expCols(input logic [31:0] t0);
    return 11'(((t0 & 32'hFC) + 4) * 4);
  endfunction

  function automatic logic [10:0] expRows(input logic [31:0] t1);
    return 11'((t1 & 32'h3FF) + 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int v = 0; v < 3; v++) begin
      for (int k = 0; k < 4; k++) mT[v][k] = '0;
      mUp[v] = '0; mLo[v] = '0; mCtrl[v] = '0; mMask[v] = '0; mRaw[v] = '0;
    end
    mRel = 1'b0;
  endtask

  task automatic modelEdge(input logic wr, input int idx, input logic [31:0] d, input logic tk);
    for (int v = 0; v < 3; v++) begin
      logic en0;
      en0 = mEn(v);
      if (wr && idx < 'h3F8) begin
        case (idx)
          0, 1, 2, 3: mT[v][idx] = d;
          4: mUp[v] = d;
          5: mLo[v] = d;
          6: if (v != 0) mCtrl[v] = d; else mMask[v] = d;
          7: if (v != 0) mMask[v] = d; else mCtrl[v] = d;
          10: mRaw[v] = mRaw[v] & ~d[3:2];
          default: ;
        endcase
      end
      if (tk && en0) mRaw[v] = 2'b11;
    end
    mRel = wr;
  endtask

  // check static outputs of every instance
  task automatic checkOutputs();
    for (int v = 0; v < 3; v++) begin
      chk("R3 cols", 32'(cols[v]), 32'(expCols(mT[v][0])));
      chk("R4 rows", 32'(rows[v]), 32'(expRows(mT[v][1])));
      chk("R5 enabled", 32'(en[v]), 32'(mEn(v)));
      chk("R5 bpp", 32'(bpp[v]), 32'(mCtrl[v][3:1]));
      chk("R5 flags", {29'd0, bgr[v], beb[v], bep[v]},
          {29'd0, mCtrl[v][8], mCtrl[v][9], mCtrl[v][10]});
      chk("R1 bases", upB[v] ^ {loB[v][15:0], loB[v][31:16]},
          mUp[v] ^ {mLo[v][15:0], mLo[v][31:16]});
      chk("R8 irq", 32'(irqO[v]), 32'(|(mRaw[v] & mMask[v][3:2])));
      chk("R11 reload", 32'(rel[v]), 32'(mRel));
    end
  endtask

  task automatic checkRead(input int idx, input string req);
    busAddr = 12'(idx << 2);
    #1;
    for (int v = 0; v < 3; v++) chk(req, rd[v], expRead(v, idx));
  endtask

  // one bus cycle: drive at negedge, model at posedge, check at next negedge
  task automatic cycle(input logic wr, input int idx, input logic [31:0] d, input logic tk);
    @(negedge clk);
    busWrite = wr; busAddr = 12'(idx << 2); busWdata = d; frameTick = tk;
    @(posedge clk);
    modelEdge(wr, idx, d, tk);
    @(negedge clk);
    busWrite = 1'b0; frameTick = 1'b0;
    #1;
    checkOutputs();
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i <= 12; i++) checkRead(i, req);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    miscompares++;
    vectors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R12: reset state
    checkOutputs();
    sweep("R12 reset read");

    // R9: identification bytes
    for (int s = 0; s < 8; s++) checkRead('h3F8 + s, "R9 id byte");

    // R3/R4 boundaries, neighbour bits toggled
    cycle(1'b1, 0, 32'h0000_0000, 1'b0);
    cycle(1'b1, 0, 32'hFFFF_FF03, 1'b0);
    cycle(1'b1, 0, 32'h0000_00FC, 1'b0);
    cycle(1'b1, 1, 32'hFFFF_FC00, 1'b0);
    cycle(1'b1, 1, 32'h0000_03FF, 1'b0);
    cycle(1'b1, 1, 32'hABCD_E123, 1'b0);

    // R2/R5/R6: enable via index 6 and 7 with the same word, mask via both
    cycle(1'b1, 6, 32'h0000_0F0D, 1'b0);
    cycle(1'b1, 7, 32'h0000_0F0D, 1'b0);
    cycle(1'b0, 0, 32'h0, 1'b1);
    sweep("R2 swap map");
    // R6: tick wins over same-cycle clear
    cycle(1'b1, 10, 32'hFFFF_FFFF, 1'b1);
    checkRead(8, "R6 tick beats clear");
    // R8: partial clear
    cycle(1'b1, 10, 32'h0000_0004, 1'b0);
    checkRead(8, "R8 partial clear");
    checkRead(9, "R8 masked");
    // R7: disable (enable set, power clear) then tick
    cycle(1'b1, 10, 32'hFFFF_FFFF, 1'b0);
    cycle(1'b1, 6, 32'h0000_0001, 1'b0);
    cycle(1'b1, 7, 32'h0000_0001, 1'b0);
    cycle(1'b0, 0, 32'h0, 1'b1);
    checkRead(8, "R7 disabled tick");
    // R10: unmapped and id writes change nothing
    cycle(1'b1, 13, 32'hDEAD_BEEF, 1'b0);
    cycle(1'b1, 'h3F9, 32'hDEAD_BEEF, 1'b0);
    cycle(1'b1, 'h100, 32'hDEAD_BEEF, 1'b0);
    sweep("R10 unmapped write");
    checkRead(13, "R10 unmapped read");
    checkRead('h200, "R10 unmapped read");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int r, idx;
      logic [31:0] d;
      logic wr, tk;
      r  = $urandom % 100;
      wr = (r < 70);
      tk = (($urandom % 4) == 0);
      d  = $urandom;
      if (($urandom % 10) == 0) idx = 'h3F8 + ($urandom % 8);
      else if (($urandom % 10) == 0) idx = 13 + ($urandom % 100);
      else idx = $urandom % 13;
      if (idx == 6 || idx == 7) d[11] = ($urandom % 2);
      cycle(wr, idx, d, tk);
      checkRead($urandom % 13, "R1 random read");
      if ((n % 100) == 0) sweep("R1 random sweep");
    end

    finish();
  end

endmodule